// File: doc/BRIEF.md
# Operand-Stack Arithmetic Unit

This block is an evaluation stack with an arithmetic and logic unit wired to its two uppermost entries. It takes one command per cycle through a valid strobe, a 4-bit operation code and a data word. Commands can push a word, pop the top word to an output register, or combine the top entries arithmetically or logically. Expressions are evaluated in postfix order, and no operand needs an address: every operation reads the stack top and the entry just under it.

Every legal command takes effect at the clock edge that samples it. The popped word, the zero and carry flags, and two misuse flags are all registered outputs. The stack is held in on-chip storage sixteen entries deep by default. A command that would take an entry from an empty stack, or put one on a full stack, raises a misuse flag and leaves the stack as it was.

Top module: `stack_alu_core`

## Requirements
- R1: After synchronous reset the stack is empty and pop_data, pop_valid, flag_zero, flag_carry, err_underflow and err_overflow are all 0.
- R2: Push (code 1) stores cmd_data on top. Pop (code 2) removes the top entry, so entries come back in last-in-first-out order. The removed word appears on pop_data with pop_valid high in the cycle after the command, and pop_valid is high for that one cycle only.
- R3: Binary operations (codes 3 to 8) consume the top entry T and the entry below it N, and leave one result on top. Subtract (code 4) gives N minus T. Hence push A, push B, add, push C, push D, subtract, multiply, pop returns (A+B)×(C−D).
- R4: Add sets flag_carry to bit 16 of the unsigned 17-bit sum. Subtract sets flag_carry to 1 when N is less than T (unsigned borrow). flag_zero is 1 when the 16-bit result is zero.
- R5: Multiply (code 5) keeps the low 16 bits of N×T.
- R6: AND (6), OR (7) and XOR (8) are bitwise on N and T.
- R7: Compare (code 9) sets flag_zero and flag_carry as subtract does. It leaves both operands on the stack unchanged.
- R8: Negate (10), increment (11), decrement (12) and NOT (13) replace only the top entry. They set flag_zero from the result and clear flag_carry.
- R9: Pop or any unary operation on an empty stack, and any binary or compare operation with fewer than two entries, set err_underflow and leave the stack untouched.
- R10: A push onto a full stack (16 entries) sets err_overflow and is discarded.
- R11: Each accepted command rewrites both misuse flags, so the next legal command clears them. Push, pop and rejected commands leave flag_zero and flag_carry unchanged.
- R12: With cmd_valid low, and for code 0 or the unused codes 14 and 15, the stack and pop_valid are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe; the command is taken at this edge |
| cmd_op | input | 4 | Operation code |
| cmd_data | input | 16 | Word to push |
| pop_data | output | 16 | Last popped word |
| pop_valid | output | 1 | One-cycle pulse after a pop |
| flag_zero | output | 1 | Result of last arithmetic/logic operation was zero |
| flag_carry | output | 1 | Carry or borrow of last add, subtract or compare |
| err_underflow | output | 1 | Last command needed more entries than held |
| err_overflow | output | 1 | Last command pushed onto a full stack |

## Verification
A wrong depth count or a corrupted entry stays hidden inside the block until a later command reads it. The bench therefore ends each scenario by popping, so that the contents show up on pop_data the cycle after each pop. A depth that is off by one shows up at the edge of the stack. There, a misuse flag rises one cycle too early or too late, and the check that follows a push to sixteen entries or a pop from empty reports it. Flag faults show up one cycle after the operation that sets them. The bench also pushes and pops after an operation that set the flags, to expose any flag that is not held.

// File: rtl/stkalu_pkg.sv
package stkalu_pkg;
  typedef enum logic [3:0] {
    OP_NOP  = 4'd0,
    OP_PUSH = 4'd1,
    OP_POP  = 4'd2,
    OP_ADD  = 4'd3,
    OP_SUB  = 4'd4,
    OP_MUL  = 4'd5,
    OP_AND  = 4'd6,
    OP_OR   = 4'd7,
    OP_XOR  = 4'd8,
    OP_CMP  = 4'd9,
    OP_NEG  = 4'd10,
    OP_INC  = 4'd11,
    OP_DEC  = 4'd12,
    OP_NOT  = 4'd13
  } stk_op_e;
endpackage

// File: rtl/stkalu_stack.sv
module stkalu_stack #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16,
  parameter int IDX_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  top_idx,
  input  logic [IDX_W-1:0]  nxt_idx,
  output logic [DATA_W-1:0] top_q,
  output logic [DATA_W-1:0] nxt_q
);
  // Single write port, two asynchronous read ports (distributed RAM shape)
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
  end

  assign top_q = mem[top_idx];
  assign nxt_q = mem[nxt_idx];
endmodule

// File: rtl/stkalu_alu.sv
module stkalu_alu
  import stkalu_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [3:0]        op,
  input  logic [DATA_W-1:0] nxt,
  input  logic [DATA_W-1:0] top,
  output logic [DATA_W-1:0] result,
  output logic              zero,
  output logic              carry
);
  logic [DATA_W:0] wide;

  always_comb begin
    case (op)
      OP_ADD:         wide = {1'b0, nxt} + {1'b0, top};
      OP_SUB, OP_CMP: wide = {1'b0, nxt} - {1'b0, top};
      OP_MUL:         wide = {1'b0, DATA_W'(nxt * top)};
      OP_AND:         wide = {1'b0, nxt & top};
      OP_OR:          wide = {1'b0, nxt | top};
      OP_XOR:         wide = {1'b0, nxt ^ top};
      OP_NEG:         wide = {1'b0, DATA_W'(-top)};
      OP_INC:         wide = {1'b0, DATA_W'(top + DATA_W'(1))};
      OP_DEC:         wide = {1'b0, DATA_W'(top - DATA_W'(1))};
      OP_NOT:         wide = {1'b0, ~top};
      default:        wide = '0;
    endcase
  end

  assign result = wide[DATA_W-1:0];
  assign zero   = (wide[DATA_W-1:0] == '0);
  assign carry  = wide[DATA_W];
endmodule

// File: rtl/stkalu_ctrl.sv
module stkalu_ctrl
  import stkalu_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CNT_W = $clog2(DEPTH + 1),
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic             cmd_valid,
  input  logic [3:0]       cmd_op,
  input  logic [CNT_W-1:0] cnt,
  output logic             under,
  output logic             over,
  output logic             accept,
  output logic [CNT_W-1:0] cnt_nxt,
  output logic             wr_en,
  output logic             wr_push,
  output logic [IDX_W-1:0] wr_idx,
  output logic [IDX_W-1:0] top_idx,
  output logic [IDX_W-1:0] nxt_idx,
  output logic             do_pop,
  output logic             upd_flags
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic [1:0] need;
  logic       is_push, is_pop, is_bin, is_cmp, is_un;

  always_comb begin
    is_push = (cmd_op == OP_PUSH);
    is_pop  = (cmd_op == OP_POP);
    is_cmp  = (cmd_op == OP_CMP);
    is_bin  = (cmd_op >= OP_ADD) && (cmd_op <= OP_XOR);
    is_un   = (cmd_op >= OP_NEG) && (cmd_op <= OP_NOT);
    need    = (is_bin || is_cmp) ? 2'd2 : ((is_pop || is_un) ? 2'd1 : 2'd0);
  end

  assign top_idx = IDX_W'(cnt - CNT_W'(1));
  assign nxt_idx = IDX_W'(cnt - CNT_W'(2));

  assign under  = cmd_valid && (cnt < CNT_W'(need));
  assign over   = cmd_valid && is_push && (cnt == FULL);
  assign accept = cmd_valid && !under && !over;

  always_comb begin
    cnt_nxt = cnt;
    wr_en   = 1'b0;
    wr_idx  = top_idx;
    if (accept) begin
      if (is_push) begin
        cnt_nxt = cnt + CNT_W'(1);
        wr_en   = 1'b1;
        wr_idx  = IDX_W'(cnt);
      end else if (is_pop) begin
        cnt_nxt = cnt - CNT_W'(1);
      end else if (is_bin) begin
        cnt_nxt = cnt - CNT_W'(1);
        wr_en   = 1'b1;
        wr_idx  = nxt_idx;
      end else if (is_un) begin
        wr_en   = 1'b1;
      end
    end
  end

  assign wr_push   = is_push;
  assign do_pop    = accept && is_pop;
  assign upd_flags = accept && (is_bin || is_cmp || is_un);
endmodule

// File: rtl/stack_alu_core.sv
module stack_alu_core #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [3:0]        cmd_op,
  input  logic [DATA_W-1:0] cmd_data,
  output logic [DATA_W-1:0] pop_data,
  output logic              pop_valid,
  output logic              flag_zero,
  output logic              flag_carry,
  output logic              err_underflow,
  output logic              err_overflow
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int IDX_W = $clog2(DEPTH);

  logic [CNT_W-1:0]  cnt, cnt_nxt;
  logic              under, over, accept, wr_en, wr_push, do_pop, upd_flags;
  logic [IDX_W-1:0]  wr_idx, top_idx, nxt_idx;
  logic [DATA_W-1:0] top_q, nxt_q, alu_res, wr_data;
  logic              alu_zero, alu_carry;

  stkalu_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_ctrl (
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cnt(cnt),
    .under(under), .over(over), .accept(accept), .cnt_nxt(cnt_nxt),
    .wr_en(wr_en), .wr_push(wr_push), .wr_idx(wr_idx),
    .top_idx(top_idx), .nxt_idx(nxt_idx),
    .do_pop(do_pop), .upd_flags(upd_flags)
  );

  stkalu_alu #(.DATA_W(DATA_W)) u_alu (
    .op(cmd_op), .nxt(nxt_q), .top(top_q),
    .result(alu_res), .zero(alu_zero), .carry(alu_carry)
  );

  assign wr_data = wr_push ? cmd_data : alu_res;

  stkalu_stack #(.DATA_W(DATA_W), .DEPTH(DEPTH), .IDX_W(IDX_W)) u_stack (
    .clk(clk), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .top_idx(top_idx), .nxt_idx(nxt_idx), .top_q(top_q), .nxt_q(nxt_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt           <= '0;
      pop_data      <= '0;
      pop_valid     <= 1'b0;
      flag_zero     <= 1'b0;
      flag_carry    <= 1'b0;
      err_underflow <= 1'b0;
      err_overflow  <= 1'b0;
    end else begin
      pop_valid <= 1'b0;
      if (cmd_valid) begin
        err_underflow <= under;
        err_overflow  <= over;
      end
      if (accept) cnt <= cnt_nxt;
      if (do_pop) begin
        pop_data  <= top_q;
        pop_valid <= 1'b1;
      end
      if (upd_flags) begin
        flag_zero  <= alu_zero;
        flag_carry <= alu_carry;
      end
    end
  end
endmodule

// File: rtl/stkalu_chk.sv
module stkalu_chk
  import stkalu_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             cmd_valid,
  input logic [3:0]       cmd_op,
  input logic [CNT_W-1:0] cnt,
  input logic             pop_valid,
  input logic             err_underflow,
  input logic             err_overflow
);
  // R10
  depth_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_W'(DEPTH));

  // R9
  err_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(err_underflow && err_overflow));

  // R10
  ovf_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(err_overflow) |-> $past(cmd_valid && (cmd_op == OP_PUSH)));

  // R9
  err_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (err_underflow || err_overflow) |-> (cnt == $past(cnt)));

  // R2
  pop_depth_chk: assert property (@(posedge clk) disable iff (rst)
    pop_valid |-> (cnt == CNT_W'($past(cnt) - CNT_W'(1))));

  // R12
  idle_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(cmd_valid) |-> ($stable(cnt) && !pop_valid));
endmodule

bind stack_alu_core stkalu_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .cnt(cnt), .pop_valid(pop_valid),
  .err_underflow(err_underflow), .err_overflow(err_overflow)
);

// File: tb/stack_alu_core_bench.sv
`timescale 1ns/1ps
module stack_alu_core_bench;
  import stkalu_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [3:0]  cmd_op = 4'd0;
  logic [15:0] cmd_data = 16'd0;
  logic [15:0] pop_data;
  logic        pop_valid, flag_zero, flag_carry, err_underflow, err_overflow;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  stack_alu_core u_stack_alu_core (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_data(cmd_data), .pop_data(pop_data), .pop_valid(pop_valid),
    .flag_zero(flag_zero), .flag_carry(flag_carry),
    .err_underflow(err_underflow), .err_overflow(err_overflow)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drives one command for one edge; returns at the negedge after it.
  task automatic issue(input logic [3:0] op, input logic [15:0] d = 16'd0);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 4'd0; cmd_data = 16'd0;
  endtask

  task automatic pop_expect(input string req, input logic [15:0] exp);
    issue(OP_POP);
    chk({req, " pop_valid"}, {31'd0, pop_valid}, 32'd1);
    chk({req, " pop_data"}, {16'd0, pop_data}, {16'd0, exp});
  endtask

  task automatic t_reset();
    chk("R1 pop_data", {16'd0, pop_data}, 32'd0);
    chk("R1 pop_valid", {31'd0, pop_valid}, 32'd0);
    chk("R1 flags", {30'd0, flag_zero, flag_carry}, 32'd0);
    chk("R1 errors", {30'd0, err_underflow, err_overflow}, 32'd0);
    issue(OP_POP);
    chk("R1 empty after reset", {31'd0, err_underflow}, 32'd1);
  endtask

  task automatic t_lifo();
    issue(OP_PUSH, 16'h1111);
    issue(OP_PUSH, 16'h2222);
    issue(OP_PUSH, 16'h3333);
    pop_expect("R2 lifo first", 16'h3333);
    @(negedge clk);
    chk("R2 pulse one cycle", {31'd0, pop_valid}, 32'd0);
    pop_expect("R2 lifo second", 16'h2222);
    pop_expect("R2 lifo third", 16'h1111);
  endtask

  task automatic t_expr();
    issue(OP_PUSH, 16'd7);
    issue(OP_PUSH, 16'd5);
    issue(OP_ADD);
    issue(OP_PUSH, 16'd9);
    issue(OP_PUSH, 16'd3);
    issue(OP_SUB);
    issue(OP_MUL);
    pop_expect("R3 (7+5)*(9-3)", 16'd72);
    issue(OP_POP);
    chk("R3 single result left", {31'd0, err_underflow}, 32'd1);
  endtask

  task automatic t_carry();
    issue(OP_PUSH, 16'hFFFF);
    issue(OP_PUSH, 16'h0002);
    issue(OP_ADD);
    chk("R4 add carry/zero", {30'd0, flag_carry, flag_zero}, 32'd2);
    issue(OP_PUSH, 16'h0BAD);
    pop_expect("R11 push/pop", 16'h0BAD);
    chk("R11 flags held over push/pop", {30'd0, flag_carry, flag_zero}, 32'd2);
    pop_expect("R4 add wraps", 16'h0001);
    issue(OP_PUSH, 16'd5);
    issue(OP_PUSH, 16'd5);
    issue(OP_SUB);
    chk("R4 sub equal flags", {30'd0, flag_carry, flag_zero}, 32'd1);
    pop_expect("R4 sub equal", 16'd0);
    issue(OP_PUSH, 16'd3);
    issue(OP_PUSH, 16'd5);
    issue(OP_SUB);
    chk("R4 sub borrow", {30'd0, flag_carry, flag_zero}, 32'd2);
    pop_expect("R4 sub order", 16'hFFFE);
  endtask

  task automatic t_mul();
    issue(OP_PUSH, 16'h1234);
    issue(OP_PUSH, 16'h0100);
    issue(OP_MUL);
    pop_expect("R5 mul low half", 16'h3400);
  endtask

  task automatic t_logic();
    issue(OP_PUSH, 16'hF0F0); issue(OP_PUSH, 16'h0FF0); issue(OP_AND);
    pop_expect("R6 and", 16'h00F0);
    issue(OP_PUSH, 16'hF0F0); issue(OP_PUSH, 16'h0FF0); issue(OP_OR);
    pop_expect("R6 or", 16'hFFF0);
    issue(OP_PUSH, 16'hF0F0); issue(OP_PUSH, 16'h0FF0); issue(OP_XOR);
    pop_expect("R6 xor", 16'hFF00);
  endtask

  task automatic t_cmp();
    issue(OP_PUSH, 16'd3);
    issue(OP_PUSH, 16'd9);
    issue(OP_CMP);
    chk("R7 cmp borrow", {30'd0, flag_carry, flag_zero}, 32'd2);
    pop_expect("R7 top kept", 16'd9);
    pop_expect("R7 next kept", 16'd3);
    issue(OP_PUSH, 16'd9);
    issue(OP_PUSH, 16'd9);
    issue(OP_CMP);
    chk("R7 cmp equal", {30'd0, flag_carry, flag_zero}, 32'd1);
    pop_expect("R7 equal top kept", 16'd9);
    pop_expect("R7 equal next kept", 16'd9);
  endtask

  task automatic t_unary();
    issue(OP_PUSH, 16'h00AA);
    issue(OP_PUSH, 16'd5);
    issue(OP_NEG);
    pop_expect("R8 neg", 16'hFFFB);
    issue(OP_INC);
    pop_expect("R8 inc below untouched", 16'h00AB);
    issue(OP_PUSH, 16'd0);
    issue(OP_DEC);
    chk("R8 dec clears carry", {30'd0, flag_carry, flag_zero}, 32'd0);
    pop_expect("R8 dec", 16'hFFFF);
    issue(OP_PUSH, 16'hFFFF);
    issue(OP_NOT);
    chk("R8 not zero flag", {31'd0, flag_zero}, 32'd1);
    pop_expect("R8 not", 16'h0000);
  endtask

  task automatic t_underflow();
    issue(OP_ADD);
    chk("R9 binary on empty", {31'd0, err_underflow}, 32'd1);
    issue(OP_NEG);
    chk("R9 unary on empty", {31'd0, err_underflow}, 32'd1);
    issue(OP_PUSH, 16'h0004);
    chk("R11 error cleared", {31'd0, err_underflow}, 32'd0);
    issue(OP_SUB);
    chk("R9 binary with one", {31'd0, err_underflow}, 32'd1);
    issue(OP_CMP);
    chk("R9 cmp with one", {31'd0, err_underflow}, 32'd1);
    pop_expect("R9 stack untouched", 16'h0004);
    chk("R11 error cleared by pop", {31'd0, err_underflow}, 32'd0);
  endtask

  task automatic t_overflow();
    for (int i = 1; i <= 16; i++) issue(OP_PUSH, 16'(i));
    chk("R10 full no error", {31'd0, err_overflow}, 32'd0);
    issue(OP_PUSH, 16'hBEEF);
    chk("R10 overflow flag", {31'd0, err_overflow}, 32'd1);
    pop_expect("R10 push dropped", 16'd16);
    chk("R11 overflow cleared", {31'd0, err_overflow}, 32'd0);
    for (int i = 15; i >= 1; i--) pop_expect("R10 contents", 16'(i));
    issue(OP_POP);
    chk("R10 emptied", {31'd0, err_underflow}, 32'd1);
  endtask

  task automatic t_idle();
    issue(OP_PUSH, 16'd1);
    issue(OP_PUSH, 16'd2);
    @(negedge clk);
    cmd_op = OP_POP;
    repeat (3) @(negedge clk);
    chk("R12 no strobe no pop", {31'd0, pop_valid}, 32'd0);
    cmd_op = 4'd0;
    issue(4'd14);
    chk("R12 unused code no pop", {31'd0, pop_valid}, 32'd0);
    issue(4'd15);
    issue(OP_NOP);
    pop_expect("R12 stack unchanged top", 16'd2);
    pop_expect("R12 stack unchanged next", 16'd1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_lifo();
    t_expr();
    t_carry();
    t_mul();
    t_logic();
    t_cmp();
    t_unary();
    t_underflow();
    t_overflow();
    t_idle();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule